// File: doc/BRIEF.md
# Oversampled Manchester Data Decoder

This block recovers data bits from a Manchester-coded serial line. It needs no phase-locked loop. A free-running local clock samples the line. That clock is not related to the sender's clock, and it runs at about `SAMPLES_PER_BIT` times the bit rate (nominally eight). The line passes through a two-flop synchronizer, and every change of level is marked as a transition. Each bit carries a guaranteed transition at its centre, and its direction gives the bit value: low-to-high is a 1 and high-to-low is a 0. A transition at the border between two bits appears only when two adjacent bits are equal. Such a transition is rejected by a pulse-width window. The window opens a little over two-thirds of a bit period after the last accepted centre transition.

A three-state controller manages lock. **IDLE** waits for the first transition; the move *IDLE→HUNT (anchor)* takes that transition as a provisional centre. **HUNT** counts transitions that arrive after the window closes. A transition inside the window causes *HUNT→HUNT (re-anchor)*: the count restarts from that transition. After `LOCK_EDGES` well-spaced transitions, *HUNT→LOCKED (acquire)* fires. **LOCKED** ignores transitions inside the window and strobes one bit for each transition outside it. *HUNT→IDLE (give up)* and *LOCKED→IDLE (drop)* are taken when no centre transition has been accepted for more than two nominal bit periods.

The sender starts each frame with a preamble of alternating bits, beginning with a 1 while the idle line is low. In that pattern every transition is a centre transition, so the controller cannot settle on the bit borders. The preamble bits used during acquisition produce no strobe.

Top module: `manchester_rx`

## Requirements
- R1: While reset is applied and right after it is released, `rx_lock` and `rx_valid` are both low.
- R2: Each accepted centre transition produces exactly one one-cycle `rx_valid` pulse. In that pulse, `rx_bit` equals the line level after the transition: 1 for a low-to-high centre transition and 0 for a high-to-low one.
- R3: A transition that arrives fewer than WINDOW = (11*SAMPLES_PER_BIT+8)/16 cycles after the last accepted centre transition is treated as a bit-border transition and produces no strobe. The first transition at or after WINDOW cycles is accepted. Runs of equal bits therefore decode correctly.
- R4: In HUNT, the first transition is an anchor, and lock is set on the `LOCK_EDGES`-th accepted transition after it. Only transitions that follow the lock-setting one produce strobes. For a preamble of P alternating bits, P-1-`LOCK_EDGES` preamble bits are strobed; with P ≤ `LOCK_EDGES` no lock is reached at all. `rx_valid` is never high while `rx_lock` is low.
- R5: During acquisition, a transition inside the window restarts the count. A line that toggles every half bit (a long run of equal bits with no preamble) therefore never gains lock and produces no strobe.
- R6: `rx_lock` stays high for at least one bit period after the last accepted centre transition. It falls once more than 2*SAMPLES_PER_BIT cycles pass with no accepted centre transition. The controller then returns to IDLE and needs a new preamble.
- R7: With the default parameters, frames decode correctly for actual bit periods of 7, 8 and 9 sample cycles.
- R8: Two `rx_valid` pulses are never on adjacent cycles and are always at least WINDOW cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, free running |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous Manchester line, idle low |
| rx_bit | output | 1 | Last recovered data bit |
| rx_valid | output | 1 | One-cycle strobe for each recovered bit |
| rx_lock | output | 1 | High while locked to centre transitions |

## Verification
The hardest state to reach from the ports is a HUNT phase that keeps re-anchoring forever. This needs a line whose transitions always fall inside the window. The bench reaches it by sending a long run of equal bits with no preamble, and separately a preamble that is one bit too short to complete acquisition. It then checks that no strobe appears and that lock stays low. Bit-border rejection is stressed with frames of all ones and all zeros, in which every bit has a border transition. Randomly chosen bit periods of 7 to 9 cycles move the centre and border transitions to both sides of nominal.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCKED = 2'd2
    } mdec_state_e;
endpackage

// File: rtl/mdec_sync.sv
module mdec_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic edge_o
);
    logic [2:0] stg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= 3'b000;
        end else begin
            stg_q <= {stg_q[1:0], line_i};
        end
    end

    assign level_o = stg_q[1];
    assign edge_o  = stg_q[1] ^ stg_q[2];
endmodule

// File: rtl/mdec_gap.sv
module mdec_gap #(
    parameter int WIN = 6,
    parameter int TMO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic open_o,
    output logic expired_o
);
    localparam int CW  = $clog2(TMO + 2);
    localparam logic [CW-1:0] SAT = CW'(TMO + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= SAT;
        end else if (restart_i) begin
            cnt_q <= CW'(1);
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign open_o    = (cnt_q >= CW'(WIN));
    assign expired_o = (cnt_q >  CW'(TMO));

    // R3: right after a restart the window is still closed
    a_r3_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !open_o);

    // R6: no expiry can be seen in the cycle following a restart
    a_r6_no_early_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !expired_o);
endmodule

// File: rtl/mdec_fsm.sv
module mdec_fsm
    import mdec_pkg::*;
#(
    parameter int LOCK_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic level_i,
    input  logic open_i,
    input  logic expired_i,
    output logic restart_o,
    output logic bit_o,
    output logic valid_o,
    output logic lock_o
);
    localparam int RW = $clog2(LOCK_EDGES + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_EDGES - 1);

    mdec_state_e state_q, state_d;
    logic [RW-1:0] run_q, run_d;
    logic strobe;
    logic bit_q, valid_q, lock_q;

    always_comb begin
        state_d   = state_q;
        run_d     = run_q;
        restart_o = 1'b0;
        strobe    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_i) begin
                    state_d   = ST_HUNT;
                    run_d     = '0;
                    restart_o = 1'b1;
                end
            end
            ST_HUNT: begin
                if (edge_i) begin
                    restart_o = 1'b1;
                    if (open_i) begin
                        if (run_q == RUN_LAST) begin
                            state_d = ST_LOCKED;
                            run_d   = '0;
                        end else begin
                            run_d = run_q + RW'(1);
                        end
                    end else begin
                        run_d = '0;
                    end
                end else if (expired_i) begin
                    state_d = ST_IDLE;
                    run_d   = '0;
                end
            end
            ST_LOCKED: begin
                if (edge_i && open_i) begin
                    restart_o = 1'b1;
                    strobe    = 1'b1;
                end else if (expired_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                run_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q   <= 1'b0;
            valid_q <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            valid_q <= strobe;
            lock_q  <= (state_d == ST_LOCKED);
            if (strobe) begin
                bit_q <= level_i;
            end
        end
    end

    assign bit_o   = bit_q;
    assign valid_o = valid_q;
    assign lock_o  = lock_q;

    // R8: strobes are single-cycle pulses
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R4: a strobe is only issued while locked
    a_r4_strobe_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> lock_q);

    // R4: lock is gained only on a line transition
    a_r4_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(edge_i));

    // R6: lock is lost only after a quiet cycle
    a_r6_drop_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> !$past(edge_i));
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx #(
    parameter int SAMPLES_PER_BIT = 8,
    parameter int LOCK_EDGES      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    output logic rx_bit,
    output logic rx_valid,
    output logic rx_lock
);
    localparam int WINDOW  = (SAMPLES_PER_BIT * 11 + 8) / 16;
    localparam int TIMEOUT = 2 * SAMPLES_PER_BIT;

    logic level, line_edge, restart, win_open, expired;

    mdec_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (rx_line),
        .level_o (level),
        .edge_o  (line_edge)
    );

    mdec_gap #(
        .WIN (WINDOW),
        .TMO (TIMEOUT)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .open_o    (win_open),
        .expired_o (expired)
    );

    mdec_fsm #(
        .LOCK_EDGES (LOCK_EDGES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (line_edge),
        .level_i   (level),
        .open_i    (win_open),
        .expired_i (expired),
        .restart_o (restart),
        .bit_o     (rx_bit),
        .valid_o   (rx_valid),
        .lock_o    (rx_lock)
    );

    // R8: spacing watch between strobes, kept apart from the decoder's own counter
    localparam int SW = $clog2(WINDOW + 2);
    logic [SW-1:0] since_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (rx_valid) begin
            since_q <= SW'(1);
            seen_q  <= 1'b1;
        end else if (since_q != SW'(WINDOW + 1)) begin
            since_q <= since_q + SW'(1);
        end
    end

    a_r8_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && seen_q) |-> (since_q >= SW'(WINDOW)));
endmodule

// File: tb/manchester_rx_tb.sv
`timescale 1ns/1ps
module manchester_rx_tb;
    localparam int SPB = 8;
    localparam int LE  = 4;
    localparam int WIN = (SPB * 11 + 8) / 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b0;
    logic rx_bit, rx_valid, rx_lock;

    int total = 0;
    int bad = 0;
    logic got[$];
    logic exp_q[$];
    logic dat[$];

    always #5 clk = ~clk;

    manchester_rx #(.SAMPLES_PER_BIT(SPB), .LOCK_EDGES(LE)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_line  (rx_line),
        .rx_bit   (rx_bit),
        .rx_valid (rx_valid),
        .rx_lock  (rx_lock)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) got.push_back(rx_bit);
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b, input int per);
        int h1 = per / 2;
        rx_line = ~b;
        cyc(h1);
        rx_line = b;
        cyc(per - h1);
    endtask

    function automatic int strobed_preamble(input int npre);
        return (npre - 1 - LE > 0) ? (npre - 1 - LE) : 0;
    endfunction

    // mode: 0 random, 1 all ones, 2 all zeros, 3 alternating
    task automatic frame(input int per, input int npre, input int ndat, input int mode,
                         input bit want_lock, input string tag);
        got.delete();
        exp_q.delete();
        dat.delete();
        for (int i = 0; i < ndat; i++) begin
            case (mode)
                0: dat.push_back(logic'($urandom % 2));
                1: dat.push_back(1'b1);
                2: dat.push_back(1'b0);
                default: dat.push_back(logic'((i % 2) == 0));
            endcase
        end
        if (want_lock) begin
            for (int i = LE + 1; i < npre; i++) exp_q.push_back(logic'((i % 2) == 0));
            foreach (dat[i]) exp_q.push_back(dat[i]);
        end
        for (int i = 0; i < npre; i++) send_bit(logic'((i % 2) == 0), per);
        foreach (dat[i]) send_bit(dat[i], per);
        rx_line = 1'b0;
        chk(rx_lock == want_lock, {tag, " R4 lock at frame end"}, int'(rx_lock), int'(want_lock));
        cyc(SPB);
        chk(rx_lock == want_lock, {tag, " R6 lock held one bit after last centre"},
            int'(rx_lock), int'(want_lock));
        cyc(3 * SPB);
        chk(rx_lock == 1'b0, {tag, " R6 lock dropped after quiet line"}, int'(rx_lock), 0);
        chk(got.size() == exp_q.size(), {tag, " R2 R4 strobe count"}, got.size(), exp_q.size());
        if (want_lock) begin
            chk(exp_q.size() == strobed_preamble(npre) + ndat, {tag, " R4 preamble discard"},
                exp_q.size(), strobed_preamble(npre) + ndat);
        end
        for (int i = 0; i < exp_q.size() && i < got.size(); i++) begin
            chk(got[i] == exp_q[i], {tag, " R2 R3 decoded bit"}, int'(got[i]), int'(exp_q[i]));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cyc(1);
        chk(rx_lock == 1'b0, "R1 lock in reset", int'(rx_lock), 0);
        chk(rx_valid == 1'b0, "R1 valid in reset", int'(rx_valid), 0);
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk(rx_lock == 1'b0, "R1 lock after reset", int'(rx_lock), 0);
        chk(rx_valid == 1'b0, "R1 valid after reset", int'(rx_valid), 0);

        frame(SPB, 10, 16, 0, 1'b1, "random");
        frame(SPB, 10, 12, 1, 1'b1, "ones R3");
        frame(SPB, 10, 12, 2, 1'b1, "zeros R3");
        frame(SPB, 10, 8, 3, 1'b1, "alternate");
        frame(SPB - 1, 10, 20, 0, 1'b1, "slow clock R7");
        frame(SPB + 1, 10, 20, 0, 1'b1, "fast clock R7");
        frame(SPB, LE, 0, 0, 1'b0, "short preamble R4");
        frame(SPB, LE + 1, 6, 0, 1'b1, "exact preamble R4");
        frame(SPB, 0, 24, 1, 1'b0, "half-bit toggling R5");
        for (int k = 0; k < 4; k++) begin
            frame(SPB - 1 + int'($urandom % 3), 8 + int'($urandom % 6),
                  10 + int'($urandom % 10), 0, 1'b1, "constrained random R7");
        end
        chk(WIN == 6, "R3 window for default ratio", WIN, 6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule